// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 39-bit virtual address into a physical address by walking a three-level radix page table held in memory. A request carries the virtual address, the physical base of the top table, the kind of access (load, store or fetch), the privilege of the requester, a flag that lets loads read execute-only pages, a flag that lets supervisor code touch user pages, and an incoming global flag. The walker then fetches one 8-byte entry per level through a plain request/response memory port.

At each level the walker decodes the entry. It follows pointer entries downward and stops at the first leaf, which may be a 4 KiB page, a 2 MiB superpage or a 1 GiB superpage. It then reports a single result: either a translation, or a failure with one of four codes. A translation carries the physical address, the leaf entry, the entry's address, the level and the accumulated global flag. Superpage leaves must be naturally aligned. The virtual page bits below the superpage size are merged into the physical page number.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: The walk starts at level 2. At level L the entry address is the current table base plus 8 times VPN[L]. VPN[L] is virtual-address bits [12+9L+8 : 12+9L]. Each level issues exactly one read, which is held with a stable address until accepted. A walk issues one read per level it visits.
- R3: A memory response with `mem_rsp_err` set ends the walk with `fail_code` 0 (access fault) at the current level.
- R4: An entry is invalid when bit 0 (V) is 0, or when bit 2 (W) is 1 while bit 1 (R) is 0. An invalid entry ends the walk with `fail_code` 1. A pointer entry (V=1, R=W=X=0, X being bit 3) found at level 0 also gives `fail_code` 1.
- R5: A pointer entry above level 0 makes the walker descend one level. The next table base is the entry's PPN (bits 53:10) shifted left by 12.
- R6: At a leaf, a permission check is made. Access codes are: 0 load, 1 store, 2 fetch. `req_priv_s` is 1 for supervisor and 0 for user. Bit 4 (U) marks a user page. User mode needs U=1. Supervisor mode on a U=1 page needs the SUM flag and is never allowed to fetch. A load needs R, or X with MXR set. A store needs W. A fetch needs X. Failure gives `fail_code` 2, and this check takes priority over the alignment check.
- R7: A leaf at level L>0 whose PPN has any of its low 9L bits set ends the walk with `fail_code` 3 (misaligned superpage).
- R8: On success `ok` is 1 and `res_paddr` is {leaf PPN OR (VPN AND low-9L mask), VA[11:0]}. The outputs also give the leaf entry, its physical address and its level L.
- R9: `res_global` is the OR of `req_global` and bit 5 (G) of every entry read during the walk.
- R10: `done` is a pulse lasting one cycle, after which the walker is idle again. `req_ready` is 0 for the whole walk, and requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when req_ready is 1) |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 39 | Virtual address |
| req_root | input | 56 | Physical base of the level-2 table |
| req_access | input | 2 | 0 load, 1 store, 2 fetch |
| req_priv_s | input | 1 | 1 supervisor, 0 user |
| req_mxr | input | 1 | Loads may read execute-only pages |
| req_sum | input | 1 | Supervisor may access user pages |
| req_global | input | 1 | Incoming global flag |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Entry address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| mem_rsp_err | input | 1 | Read faulted |
| done | output | 1 | Result valid (one cycle) |
| ok | output | 1 | Translation succeeded |
| fail_code | output | 2 | 0 access, 1 invalid, 2 permission, 3 misaligned |
| res_paddr | output | 56 | Translated physical address |
| res_pte | output | 64 | Last entry read |
| res_pte_addr | output | 56 | Address of that entry |
| res_level | output | 2 | Level where the walk ended |
| res_global | output | 1 | Accumulated global flag |

## Verification
The permission check and the superpage alignment check are both evaluated on the same response cycle when a leaf is found above level 0. The bench places a misaligned level-1 leaf marked as a user page. A supervisor load with SUM clear must report the permission code, not the misaligned code. A user load of the same entry must report misaligned. A second overlap is a new request presented while a walk is running and during its done cycle. The bench holds a decoy address on the request port across those cycles. It judges that the result belongs to the first address, that the read count is unchanged, and that `req_ready` stays low.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [1:0] {
        FAIL_ACCESS   = 2'd0,
        FAIL_INVALID  = 2'd1,
        FAIL_PERM     = 2'd2,
        FAIL_MISALIGN = 2'd3
    } fail_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } access_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } walk_st_e;

    localparam int FLAG_W = 6;
    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_G = 5;

endpackage

// File: rtl/entry_addr_calc.sv
module entry_addr_calc #(
    parameter int IDX_W     = 9,
    parameter int LEVELS    = 3,
    parameter int LVL_W     = 2,
    parameter int PA_W      = 56,
    parameter int ENTRY_LOG = 3
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    input  logic [PA_W-1:0]         base,
    output logic [PA_W-1:0]         addr
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx  = vpn[int'(level)*IDX_W +: IDX_W];
        addr = base + (PA_W'(idx) << ENTRY_LOG);
    end
endmodule

// File: rtl/entry_judge.sv
module entry_judge
    import walk_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [1:0]        access,
    input  logic              priv_s,
    input  logic              mxr,
    input  logic              sum,
    output logic              is_invalid,
    output logic              is_pointer,
    output logic              perm_ok,
    output logic              g_bit
);
    logic priv_ok;
    logic kind_ok;

    always_comb begin
        is_invalid = !flags[B_V] || (flags[B_W] && !flags[B_R]);
        is_pointer = flags[B_V] && !flags[B_R] && !flags[B_W] && !flags[B_X];
        g_bit      = flags[B_G];

        if (!priv_s) begin
            priv_ok = flags[B_U];
        end else if (flags[B_U]) begin
            priv_ok = sum && (access != ACC_FETCH);
        end else begin
            priv_ok = 1'b1;
        end

        case (access)
            ACC_LOAD:  kind_ok = flags[B_R] || (mxr && flags[B_X]);
            ACC_STORE: kind_ok = flags[B_W];
            ACC_FETCH: kind_ok = flags[B_X];
            default:   kind_ok = 1'b0;
        endcase

        perm_ok = priv_ok && kind_ok;
    end
endmodule

// File: rtl/leaf_compose.sv
module leaf_compose #(
    parameter int IDX_W  = 9,
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2,
    parameter int PPN_W  = 44
) (
    input  logic [PPN_W-1:0]        ppn,
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    output logic                    misaligned,
    output logic [PPN_W-1:0]        ppn_out
);
    logic [PPN_W-1:0] mask;
    logic [PPN_W-1:0] vpn_ext;

    always_comb begin
        mask       = (PPN_W'(1) << (int'(level) * IDX_W)) - PPN_W'(1);
        vpn_ext    = PPN_W'(vpn);
        misaligned = (ppn & mask) != '0;
        ppn_out    = ppn | (vpn_ext & mask);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import walk_pkg::*;
#(
    parameter int LEVELS    = 3,
    parameter int IDX_W     = 9,
    parameter int OFS_W     = 12,
    parameter int PA_W      = 56,
    parameter int PTE_W     = 64,
    parameter int ENTRY_LOG = 3,
    parameter int PPN_LSB   = 10,
    parameter int VA_W      = OFS_W + LEVELS * IDX_W,
    parameter int LVL_W     = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_root,
    input  logic [1:0]       req_access,
    input  logic             req_priv_s,
    input  logic             req_mxr,
    input  logic             req_sum,
    input  logic             req_global,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    input  logic             mem_rsp_err,
    output logic             done,
    output logic             ok,
    output logic [1:0]       fail_code,
    output logic [PA_W-1:0]  res_paddr,
    output logic [PTE_W-1:0] res_pte,
    output logic [PA_W-1:0]  res_pte_addr,
    output logic [LVL_W-1:0] res_level,
    output logic             res_global
);
    localparam int VPN_W = LEVELS * IDX_W;
    localparam int PPN_W = PA_W - OFS_W;
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        walk_st_e         st;
        logic [LVL_W-1:0] level;
        logic [PA_W-1:0]  base;
        logic [VA_W-1:0]  vaddr;
        logic [1:0]       access;
        logic             priv_s;
        logic             mxr;
        logic             sum;
        logic             glob;
        logic             ok;
        fail_e            code;
        logic [PA_W-1:0]  paddr;
        logic [PTE_W-1:0] pte;
        logic [PA_W-1:0]  pte_addr;
        logic [LVL_W-1:0] res_level;
        logic             res_glob;
    } walk_s;

    walk_s cur_q, nxt_d;

    logic [VPN_W-1:0] vpn;
    logic [PA_W-1:0]  entry_addr;
    logic             ent_invalid, ent_pointer, ent_perm_ok, ent_g;
    logic [PPN_W-1:0] ent_ppn;
    logic             sp_misaligned;
    logic [PPN_W-1:0] merged_ppn;
    logic             glob_upd;

    assign vpn     = cur_q.vaddr[VA_W-1:OFS_W];
    assign ent_ppn = mem_rsp_data[PPN_LSB +: PPN_W];

    entry_addr_calc #(
        .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W),
        .PA_W(PA_W), .ENTRY_LOG(ENTRY_LOG)
    ) u_addr (
        .vpn   (vpn),
        .level (cur_q.level),
        .base  (cur_q.base),
        .addr  (entry_addr)
    );

    entry_judge u_judge (
        .flags      (mem_rsp_data[FLAG_W-1:0]),
        .access     (cur_q.access),
        .priv_s     (cur_q.priv_s),
        .mxr        (cur_q.mxr),
        .sum        (cur_q.sum),
        .is_invalid (ent_invalid),
        .is_pointer (ent_pointer),
        .perm_ok    (ent_perm_ok),
        .g_bit      (ent_g)
    );

    leaf_compose #(
        .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W), .PPN_W(PPN_W)
    ) u_leaf (
        .ppn        (ent_ppn),
        .vpn        (vpn),
        .level      (cur_q.level),
        .misaligned (sp_misaligned),
        .ppn_out    (merged_ppn)
    );

    always_comb begin
        nxt_d    = cur_q;
        glob_upd = cur_q.glob | (ent_g & ~mem_rsp_err);
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.st     = ST_ISSUE;
                    nxt_d.level  = TOP_LVL;
                    nxt_d.base   = req_root;
                    nxt_d.vaddr  = req_vaddr;
                    nxt_d.access = req_access;
                    nxt_d.priv_s = req_priv_s;
                    nxt_d.mxr    = req_mxr;
                    nxt_d.sum    = req_sum;
                    nxt_d.glob   = req_global;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    nxt_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    nxt_d.st        = ST_FIN;
                    nxt_d.ok        = 1'b0;
                    nxt_d.code      = FAIL_ACCESS;
                    nxt_d.paddr     = '0;
                    nxt_d.pte       = mem_rsp_err ? '0 : mem_rsp_data;
                    nxt_d.pte_addr  = entry_addr;
                    nxt_d.res_level = cur_q.level;
                    nxt_d.res_glob  = glob_upd;
                    if (mem_rsp_err) begin
                        nxt_d.code = FAIL_ACCESS;
                    end else if (ent_invalid) begin
                        nxt_d.code = FAIL_INVALID;
                    end else if (ent_pointer) begin
                        if (cur_q.level == '0) begin
                            nxt_d.code = FAIL_INVALID;
                        end else begin
                            nxt_d.st    = ST_ISSUE;
                            nxt_d.level = cur_q.level - LVL_W'(1);
                            nxt_d.base  = {ent_ppn, {OFS_W{1'b0}}};
                            nxt_d.glob  = glob_upd;
                        end
                    end else if (!ent_perm_ok) begin
                        nxt_d.code = FAIL_PERM;
                    end else if (sp_misaligned) begin
                        nxt_d.code = FAIL_MISALIGN;
                    end else begin
                        nxt_d.ok    = 1'b1;
                        nxt_d.paddr = {merged_ppn, cur_q.vaddr[OFS_W-1:0]};
                    end
                end
            end
            ST_FIN: begin
                nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q           <= '0;
            cur_q.st        <= ST_IDLE;
            cur_q.code      <= FAIL_ACCESS;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready     = (cur_q.st == ST_IDLE);
    assign mem_req_valid = (cur_q.st == ST_ISSUE);
    assign mem_req_addr  = entry_addr;
    assign done          = (cur_q.st == ST_FIN);
    assign ok            = cur_q.ok;
    assign fail_code     = cur_q.code;
    assign res_paddr     = cur_q.paddr;
    assign res_pte       = cur_q.pte;
    assign res_pte_addr  = cur_q.pte_addr;
    assign res_level     = cur_q.res_level;
    assign res_global    = cur_q.res_glob;

endmodule

// File: rtl/walker_checker.sv
module walker_checker #(
    parameter int PA_W   = 56,
    parameter int LVL_W  = 2,
    parameter int LEVELS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             done,
    input logic             ok,
    input logic [1:0]       fail_code,
    input logic [LVL_W-1:0] res_level
);
    p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req_valid);

    p_hold_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || done) |-> !req_ready);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    p_misalign_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !ok && fail_code == 2'd3 |-> res_level != '0);

    p_level_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> int'(res_level) <= LEVELS - 1);

    p_ok_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && ok |-> fail_code == 2'd0);
endmodule

bind pt_walker walker_checker #(.PA_W(PA_W), .LVL_W(LVL_W), .LEVELS(LEVELS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .ok            (ok),
    .fail_code     (fail_code),
    .res_level     (res_level)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam int CLK_PERIOD = 10;
    localparam logic [55:0] ROOT = 56'h100000;
    localparam logic [55:0] L1T  = 56'h101000;
    localparam logic [55:0] L0T  = 56'h102000;
    localparam logic [55:0] L1B  = 56'h103000;
    localparam logic [63:0] FV = 64'h1, FR = 64'h2, FW = 64'h4, FX = 64'h8;
    localparam logic [63:0] FU = 64'h10, FG = 64'h20, FA = 64'h40, FD = 64'h80;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_ready;
    logic [38:0] req_vaddr = '0;
    logic [55:0] req_root = ROOT;
    logic [1:0]  req_access = 0;
    logic        req_priv_s = 1, req_mxr = 0, req_sum = 0, req_global = 0;
    logic        mem_req_valid, mem_req_ready;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 0, mem_rsp_err = 0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, ok;
    logic [1:0]  fail_code;
    logic [55:0] res_paddr, res_pte_addr;
    logic [63:0] res_pte;
    logic [1:0]  res_level;
    logic        res_global;

    int tests = 0, fails = 0, reads = 0;
    logic [63:0] mem [logic [55:0]];

    logic        r_ok, r_glob;
    logic [1:0]  r_code, r_level;
    logic [55:0] r_paddr, r_pteaddr;
    int          r_reads;

    assign mem_req_ready = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root), .req_access(req_access),
        .req_priv_s(req_priv_s), .req_mxr(req_mxr), .req_sum(req_sum),
        .req_global(req_global), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .done(done), .ok(ok), .fail_code(fail_code),
        .res_paddr(res_paddr), .res_pte(res_pte), .res_pte_addr(res_pte_addr),
        .res_level(res_level), .res_global(res_global)
    );

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            reads = reads + 1;
            mem_rsp_valid <= 1'b1;
            if (mem.exists(mem_req_addr)) begin
                mem_rsp_data <= mem[mem_req_addr];
                mem_rsp_err  <= 1'b0;
            end else begin
                mem_rsp_data <= '0;
                mem_rsp_err  <= 1'b1;
            end
        end
    end

    function automatic logic [38:0] va(input int v2, v1, v0, off);
        return {v2[8:0], v1[8:0], v0[8:0], off[11:0]};
    endfunction

    function automatic logic [63:0] ptr(input logic [43:0] p);
        return ({20'b0, p} << 10) | FV;
    endfunction

    function automatic logic [63:0] leaf(input logic [43:0] p, input logic [63:0] fl);
        return ({20'b0, p} << 10) | fl | FV;
    endfunction

    task automatic chk(input logic cond, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic run_walk(input logic [38:0] v, input logic [1:0] acc,
                            input logic pr, input logic mx, input logic sm,
                            input logic gl, input int busy);
        int n;
        @(negedge clk);
        req_valid = 1; req_vaddr = v; req_access = acc; req_priv_s = pr;
        req_mxr = mx; req_sum = sm; req_global = gl; reads = 0;
        @(negedge clk);
        req_vaddr = va(5, 10, 11, 0);
        for (int i = 0; i < busy; i++) begin
            chk(req_ready == 1'b0, "R10 busy ready", 64'(req_ready), 0);
            @(negedge clk);
        end
        if (busy == 0) req_valid = 0;
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (busy > 0) begin
            chk(req_ready == 1'b0, "R10 ready low at done", 64'(req_ready), 0);
            req_valid = 0;
        end
        if (n >= 100) chk(1'b0, "R10 walk watchdog", n, 100);
        r_ok = ok; r_code = fail_code; r_paddr = res_paddr; r_pteaddr = res_pte_addr;
        r_level = res_level; r_glob = res_global; r_reads = reads;
        @(negedge clk);
        chk(done == 1'b0, "R10 done pulse width", 64'(done), 0);
        chk(req_ready == 1'b1, "R10 idle after done", 64'(req_ready), 1);
    endtask

    task automatic exp_ok(input string tag, input logic [55:0] pa, input logic [55:0] pta,
                          input logic [1:0] lvl, input logic gl, input int rd);
        chk(r_ok == 1'b1, {tag, " ok"}, 64'(r_ok), 1);
        chk(r_paddr == pa, {tag, " paddr"}, 64'(r_paddr), 64'(pa));
        chk(r_pteaddr == pta, {tag, " pte addr"}, 64'(r_pteaddr), 64'(pta));
        chk(r_level == lvl, {tag, " level"}, 64'(r_level), 64'(lvl));
        chk(r_glob == gl, {tag, " global R9"}, 64'(r_glob), 64'(gl));
        chk(r_reads == rd, {tag, " reads R2"}, r_reads, rd);
    endtask

    task automatic exp_fail(input string tag, input logic [1:0] code,
                            input logic [1:0] lvl, input int rd);
        chk(r_ok == 1'b0, {tag, " not ok"}, 64'(r_ok), 0);
        chk(r_code == code, {tag, " code"}, 64'(r_code), 64'(code));
        chk(r_level == lvl, {tag, " level"}, 64'(r_level), 64'(lvl));
        chk(r_reads == rd, {tag, " reads R2"}, r_reads, rd);
    endtask

    function automatic logic perm_model(input logic [63:0] e, input logic [1:0] acc,
                                        input logic pr, input logic mx, input logic sm);
        logic pok, kok;
        if (!pr) pok = e[4];
        else if (e[4]) pok = sm && (acc != 2'd2);
        else pok = 1'b1;
        case (acc)
            2'd0: kok = e[1] || (mx && e[3]);
            2'd1: kok = e[2];
            default: kok = e[3];
        endcase
        return pok && kok;
    endfunction

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d expected finish", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0] ent [2];
        logic [38:0] sv  [2];
        mem[ROOT + 8]  = ptr(44'h101);
        mem[L1T + 16]  = ptr(44'h102);
        mem[L0T + 24]  = leaf(44'h5555, FR | FW | FA | FD);
        mem[L1T + 32]  = leaf(44'h200, FR | FX | FA);
        mem[ROOT + 40] = leaf(44'h40000, FR | FU | FG | FA);
        mem[ROOT + 56] = 64'h0;
        mem[ROOT + 64] = FV | FW;
        mem[L0T + 32]  = ptr(44'h7);
        mem[L0T + 40]  = leaf(44'h6000, FR | FU | FA);
        mem[L0T + 48]  = leaf(44'h6001, FX | FA);
        mem[L1T + 48]  = leaf(44'h201, FR | FA);
        mem[L1T + 56]  = leaf(44'h201, FR | FU | FA);
        mem[ROOT + 72] = ptr(44'h103) | FG;
        mem[L1B]       = leaf(44'h400, FR | FA);

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 1);
        chk(done == 1'b0, "R1 done after reset", 64'(done), 0);
        chk(mem_req_valid == 1'b0, "R1 no read after reset", 64'(mem_req_valid), 0);

        // R2 R5 R8: 4 KiB page through two pointers
        run_walk(va(1, 2, 3, 12'habc), 2'd0, 1, 0, 0, 0, 0);
        exp_ok("R8 4K", 56'h5555abc, L0T + 24, 0, 0, 3);
        run_walk(va(1, 2, 3, 12'habc), 2'd0, 1, 0, 0, 1, 0);
        exp_ok("R9 incoming global", 56'h5555abc, L0T + 24, 0, 1, 3);

        // R8 2 MiB superpage
        run_walk(va(1, 4, 9'h1ff, 12'h123), 2'd0, 1, 0, 0, 0, 0);
        exp_ok("R8 2M", 56'h3ff123, L1T + 32, 1, 0, 2);
        run_walk(va(1, 4, 9'h1ff, 12'h123), 2'd1, 1, 0, 0, 0, 0);
        exp_fail("R6 store on read-only 2M", 2'd2, 1, 2);

        // R8 1 GiB superpage with G leaf
        run_walk(va(5, 10, 11, 12'h7ff), 2'd0, 0, 0, 0, 0, 0);
        exp_ok("R8 1G", 56'h4140b7ff, ROOT + 40, 2, 1, 1);
        run_walk(va(5, 10, 11, 12'h7ff), 2'd2, 1, 0, 1, 0, 0);
        exp_fail("R6 supervisor fetch user page", 2'd2, 2, 1);

        // R9 G on pointer only
        run_walk(va(9, 0, 9'h33, 12'h44), 2'd0, 1, 0, 0, 0, 0);
        exp_ok("R9 pointer G", 56'h433044, L1B, 1, 1, 2);

        // R3 access faults
        run_walk(va(6, 0, 0, 0), 2'd0, 1, 0, 0, 0, 0);
        exp_fail("R3 fault level2", 2'd0, 2, 1);
        run_walk(va(1, 5, 0, 0), 2'd0, 1, 0, 0, 0, 0);
        exp_fail("R3 fault level1", 2'd0, 1, 2);

        // R4 invalid encodings
        run_walk(va(7, 0, 0, 0), 2'd0, 1, 0, 0, 0, 0);
        exp_fail("R4 V clear", 2'd1, 2, 1);
        run_walk(va(8, 0, 0, 0), 2'd0, 1, 0, 0, 0, 0);
        exp_fail("R4 W without R", 2'd1, 2, 1);
        run_walk(va(1, 2, 4, 0), 2'd0, 1, 0, 0, 0, 0);
        exp_fail("R4 pointer at level0", 2'd1, 0, 3);

        // R7 misaligned, and R6 priority over it
        run_walk(va(1, 6, 0, 0), 2'd0, 1, 0, 0, 0, 0);
        exp_fail("R7 misaligned 2M", 2'd3, 1, 2);
        run_walk(va(1, 7, 0, 0), 2'd0, 1, 0, 0, 0, 0);
        exp_fail("R6 permission before misalign", 2'd2, 1, 2);
        run_walk(va(1, 7, 0, 0), 2'd0, 0, 0, 0, 0, 0);
        exp_fail("R7 user misaligned", 2'd3, 1, 2);

        // R6 sweep over access, privilege, MXR, SUM on two leaves
        ent[0] = mem[L0T + 40]; sv[0] = va(1, 2, 5, 12'h010);
        ent[1] = mem[L0T + 48]; sv[1] = va(1, 2, 6, 12'h020);
        for (int e = 0; e < 2; e++) begin
            for (int a = 0; a < 3; a++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int m = 0; m < 2; m++) begin
                        for (int s = 0; s < 2; s++) begin
                            run_walk(sv[e], 2'(a), p[0], m[0], s[0], 0, 0);
                            if (perm_model(ent[e], 2'(a), p[0], m[0], s[0]))
                                exp_ok("R6 sweep allow",
                                       (e == 0) ? 56'h6000010 : 56'h6001020,
                                       (e == 0) ? L0T + 40 : L0T + 48, 0, 0, 3);
                            else
                                exp_fail("R6 sweep deny", 2'd2, 0, 3);
                        end
                    end
                end
            end
        end

        // R10 request held while busy through the done cycle
        run_walk(va(1, 2, 3, 12'h5a5), 2'd0, 1, 0, 0, 0, 3);
        exp_ok("R10 busy request ignored", 56'h55555a5, L0T + 24, 0, 0, 3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule